// File: doc/BRIEF.md
# Double-Precision to 64-bit Integer Converter

The block takes an IEEE-754 binary64 operand and produces a 64-bit two's-complement integer. It does not saturate. Values too large for 64 bits return the low 64 bits of the exact integer, so one conversion also serves unsigned use. A 2-bit rounding mode selects how discarded fraction bits are treated. A force-truncate input overrides that mode with round-toward-zero. A flush input makes subnormal operands count as exact zeros.

The conversion runs in a two-stage pipeline. The first stage classifies the operand and aligns the significand, either shifting it left or splitting it into an integer part and guard/sticky bits. The second stage rounds the magnitude and applies the sign. One operand can be accepted on every cycle. A 3-bit flag vector comes out alongside each result.

Top module: `f64_to_i64_cvt`

## Requirements
- R1: A result and its flags appear with valid_o high exactly two rising edges after the cycle in which valid_i is high, one result per accepted operand, with back-to-back operands allowed; after reset valid_o, result_o and flags_o are zero.
- R2: An operand with exponent field 0 gives result 0 and no flags when the fraction is zero (either sign) or when flush_i is high.
- R3: An operand with exponent field 0, a nonzero fraction and flush_i low has integer part 0 and a sticky bit only: inexact is set, and rounding applies (toward +inf gives 1 for a positive operand; toward -inf gives all ones for a negative one).
- R4: An operand with an all-ones exponent field (infinity or NaN) sets the invalid flag only and gives result 0.
- R5: When the unbiased exponent is 52 or more, the significand is shifted left with no rounding and no inexact from rounding; a shift of 64 or more gives result 0.
- R6: When the left shift is 11 or more, overflow and inexact are both set and the result is the wrapped low 64 bits. The single encoding 0xC3E0000000000000 is exempt and gives 0x8000000000000000 with no flags.
- R7: When the unbiased exponent is below 52, the bits shifted out set inexact if any is nonzero. A shift of 63 or more leaves integer part 0 and only a sticky bit.
- R8: Mode 2'b00 (nearest-even) adds 1 when the discarded part exceeds one half. At exactly one half it adds the integer part's LSB.
- R9: Mode 2'b01 truncates. Mode 2'b10 adds 1 to an inexact magnitude only for positive operands. Mode 2'b11 adds 1 only for negative operands.
- R10: A negative operand's rounded magnitude is negated in two's complement.
- R11: trunc_i high makes the conversion behave as mode 2'b01 whatever rmode_i is.
- R12: result_o and flags_o hold their last values on cycles when valid_o is low.
- R13: flags_o bit 2 is invalid, bit 1 is integer overflow, bit 0 is inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| operand_i | input | 64 | binary64 operand |
| rmode_i | input | 2 | Rounding mode: 00 nearest-even, 01 zero, 10 +inf, 11 -inf |
| trunc_i | input | 1 | Force round-toward-zero |
| flush_i | input | 1 | Treat subnormal operands as zero |
| valid_o | output | 1 | Result strobe |
| result_o | output | 64 | Wrapped two's-complement integer |
| flags_o | output | 3 | {invalid, overflow, inexact} |

## Verification
The bench targets the exact-half ties at odd and even integer parts. A design that rounds half up instead of to even would return 3 for 2.5. It drives 2^63 and -2^63 side by side. Dropping the exemption would flag -2^63 as an overflow, and a wrong threshold would let 2^63 through without flags. It sends subnormals under each directed mode, with and without flush. Treating these as plain zeros would lose the inexact flag and the 1 or -1 that directed rounding produces. Random operands with exponents around the 64-bit boundary confirm wrapping. A saturating design would return the maximum integer there instead of the low bits.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int EXP_W = 11;
  localparam int FRAC_W = 52;
  localparam int INT_W = 64;
  localparam int FLT_W = 1 + EXP_W + FRAC_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int SA_W = EXP_W + 2;
  localparam int SH_W = $clog2(INT_W);
  localparam int FLG_W = 3;
  localparam int FLG_INE = 0;
  localparam int FLG_OVF = 1;
  localparam int FLG_INV = 2;

  typedef enum logic [1:0] {
    RM_RNE = 2'b00,
    RM_RZ  = 2'b01,
    RM_RUP = 2'b10,
    RM_RDN = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             sign;
    logic [INT_W-1:0] mag;
    logic             guard;
    logic             sticky;
    logic             inv;
    logic             ovf;
  } align_t;
endpackage

// File: rtl/cvt_align.sv
module cvt_align
  import cvt_pkg::*;
(
  input  logic [FLT_W-1:0] op_i,
  input  logic             flush_i,
  output align_t           al_o
);
  localparam logic signed [SA_W-1:0] SHIFT_BIAS = SA_W'(BIAS + FRAC_W);
  localparam logic signed [SA_W-1:0] LIM_L = SA_W'(INT_W);
  localparam logic signed [SA_W-1:0] LIM_R = SA_W'(INT_W - 1);
  localparam logic signed [SA_W-1:0] OVF_SH = SA_W'(INT_W - FRAC_W - 1);
  localparam logic [FLT_W-1:0] MIN_ENC = {1'b1, EXP_W'(BIAS + INT_W - 1), {FRAC_W{1'b0}}};

  logic [EXP_W-1:0]       exp_f;
  logic [FRAC_W-1:0]      frac_f;
  logic signed [SA_W-1:0] shamt;
  logic signed [SA_W-1:0] rsh;
  logic [INT_W-1:0]       sig_ext;
  logic [2*INT_W-1:0]     wide;

  assign exp_f   = op_i[FLT_W-2 -: EXP_W];
  assign frac_f  = op_i[FRAC_W-1:0];
  assign shamt   = $signed({2'b00, exp_f}) - SHIFT_BIAS;
  assign rsh     = -shamt;
  assign sig_ext = {{(INT_W-FRAC_W-1){1'b0}}, 1'b1, frac_f};
  // integer part lands in the upper half, discarded bits left-justified in the lower
  assign wide    = {sig_ext, {INT_W{1'b0}}} >> rsh[SH_W-1:0];

  always_comb begin
    al_o      = '0;
    al_o.sign = op_i[FLT_W-1];
    if (exp_f == '0) begin
      if (frac_f != '0 && !flush_i) al_o.sticky = 1'b1;
    end else if (&exp_f) begin
      al_o.inv = 1'b1;
    end else if (shamt >= 0) begin
      if (shamt < LIM_L) al_o.mag = sig_ext << shamt[SH_W-1:0];
      if (shamt >= OVF_SH && op_i != MIN_ENC) al_o.ovf = 1'b1;
    end else if (rsh < LIM_R) begin
      al_o.mag    = wide[2*INT_W-1:INT_W];
      al_o.guard  = wide[INT_W-1];
      al_o.sticky = |wide[INT_W-2:0];
    end else begin
      al_o.sticky = 1'b1;
    end
  end
endmodule

// File: rtl/cvt_round.sv
module cvt_round
  import cvt_pkg::*;
(
  input  align_t           al_i,
  input  rmode_e           rm_i,
  output logic [INT_W-1:0] result_o,
  output logic [FLG_W-1:0] flags_o
);
  logic             lost;
  logic             inc;
  logic [INT_W-1:0] rounded;

  assign lost = al_i.guard | al_i.sticky;

  always_comb begin
    unique case (rm_i)
      RM_RNE:  inc = al_i.guard & (al_i.sticky | al_i.mag[0]);
      RM_RZ:   inc = 1'b0;
      RM_RUP:  inc = lost & ~al_i.sign;
      default: inc = lost & al_i.sign;
    endcase
  end

  assign rounded  = al_i.mag + INT_W'(inc);
  assign result_o = al_i.sign ? (~rounded + 1'b1) : rounded;

  always_comb begin
    flags_o          = '0;
    flags_o[FLG_INV] = al_i.inv;
    flags_o[FLG_OVF] = al_i.ovf;
    flags_o[FLG_INE] = al_i.ovf | lost;
  end
endmodule

// File: rtl/f64_to_i64_cvt.sv
module f64_to_i64_cvt
  import cvt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [FLT_W-1:0] operand_i,
  input  logic [1:0]       rmode_i,
  input  logic             trunc_i,
  input  logic             flush_i,
  output logic             valid_o,
  output logic [INT_W-1:0] result_o,
  output logic [FLG_W-1:0] flags_o
);
  align_t           al_d, al_q;
  rmode_e           rm_d, rm_q;
  logic             v1_q;
  logic [INT_W-1:0] res_d;
  logic [FLG_W-1:0] flg_d;

  assign rm_d = trunc_i ? RM_RZ : rmode_e'(rmode_i);

  cvt_align u_align (
    .op_i    (operand_i),
    .flush_i (flush_i),
    .al_o    (al_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      al_q <= '0;
      rm_q <= RM_RNE;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        al_q <= al_d;
        rm_q <= rm_d;
      end
    end
  end

  cvt_round u_round (
    .al_i     (al_q),
    .rm_i     (rm_q),
    .result_o (res_d),
    .flags_o  (flg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= v1_q;
      if (v1_q) begin
        result_o <= res_d;
        flags_o  <= flg_d;
      end
    end
  end

  p_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_q |=> valid_o);
  p_lat_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v1_q |=> !valid_o);
  p_inv_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o[FLG_INV]) |-> (result_o == '0 && flags_o[FLG_OVF:FLG_INE] == '0));
  p_ovf_ine_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o[FLG_OVF]) |-> flags_o[FLG_INE]);
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v1_q |=> ($stable(result_o) && $stable(flags_o)));
endmodule

// File: tb/f64_to_i64_cvt_tb.sv
`timescale 1ns/1ps
module f64_to_i64_cvt_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic [1:0]  rmode_i = '0;
  logic        trunc_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [2:0]  flags_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] r;
    logic [2:0]  f;
    int          cyc;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  f64_to_i64_cvt u_dut (
    .clk_i, .rst_ni, .valid_i, .operand_i, .rmode_i, .trunc_i, .flush_i,
    .valid_o, .result_o, .flags_o
  );

  // Reference from the requirements: integer part plus remainder vs half.
  function automatic void model(input logic [63:0] a, input logic [1:0] rm, input logic tr,
                                input logic fl, output logic [63:0] r, output logic [2:0] f);
    logic         sgn;
    logic [10:0]  e;
    logic [51:0]  fr;
    logic [127:0] sig, ip, rem, half;
    logic [63:0]  mag;
    logic [1:0]   m;
    logic         nz, gt, eq, inc;
    int           sh, n;
    sgn = a[63]; e = a[62:52]; fr = a[51:0];
    m = tr ? 2'b01 : rm;
    f = '0; mag = '0; nz = 0; gt = 0; eq = 0;
    if (e == 0) begin
      if (fr != 0 && !fl) nz = 1;                       // R3
    end else if (e == 11'h7ff) begin
      f[2] = 1;                                         // R4
    end else begin
      sig = {75'd0, 1'b1, fr};
      sh = int'(e) - 1075;
      if (sh >= 0) begin
        if (sh < 64) begin ip = sig << sh; mag = ip[63:0]; end
        if (sh >= 11 && a != 64'hC3E0000000000000) f[1:0] = 2'b11;  // R6
      end else begin
        n = -sh;
        if (n >= 100) nz = 1;
        else begin
          ip = sig >> n; rem = sig - (ip << n); half = 128'd1 << (n - 1);
          nz = rem != 0; gt = rem > half; eq = rem == half; mag = ip[63:0];
        end
      end
    end
    inc = 0;
    if (nz) begin
      f[0] = 1;
      case (m)
        2'b00: inc = gt | (eq & mag[0]);
        2'b01: inc = 0;
        2'b10: inc = !sgn;
        default: inc = sgn;
      endcase
    end
    mag = mag + 64'(inc);
    r = sgn ? -mag : mag;
  endfunction

  task automatic send(input logic [63:0] a, input logic [1:0] rm, input logic tr,
                      input logic fl, input string tag);
    exp_t x;
    @(negedge clk_i);
    operand_i = a; rmode_i = rm; trunc_i = tr; flush_i = fl; valid_i = 1'b1;
    model(a, rm, tr, fl, x.r, x.f);
    x.cyc = cyc; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk_i); valid_i = 1'b0; end
  endtask

  // Monitor / scoreboard
  logic [63:0] last_r = '0;
  logic [2:0]  last_f = '0;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 unexpected result act=%h exp=none", result_o);
        end else begin
          exp_t x;
          x = q.pop_front();
          checks++;
          if (result_o !== x.r || flags_o !== x.f) begin
            errors++;
            $display("FAIL %s act=%h/%b exp=%h/%b", x.tag, result_o, flags_o, x.r, x.f);
          end
          checks++;
          if (cyc - x.cyc != 2) begin
            errors++;
            $display("FAIL R1 latency act=%0d exp=2", cyc - x.cyc);
          end
        end
        last_r = result_o; last_f = flags_o;
      end else begin
        checks++;                                       // R12
        if (result_o !== last_r || flags_o !== last_f) begin
          errors++;
          $display("FAIL R12 hold act=%h/%b exp=%h/%b", result_o, flags_o, last_r, last_f);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;                                           // R1 reset state
    if (valid_o !== 1'b0 || result_o !== '0 || flags_o !== '0) begin
      errors++;
      $display("FAIL R1 reset act=%b/%h/%b exp=0/0/0", valid_o, result_o, flags_o);
    end
    rst_ni = 1'b1;
    idle(2);
    // R2 zeros and flush
    send(64'h0000000000000000, 2'b10, 0, 0, "R2");
    send(64'h8000000000000000, 2'b11, 0, 0, "R2");
    send(64'h000FFFFFFFFFFFFF, 2'b10, 0, 1, "R2");
    // R3 subnormal sticky
    send(64'h0000000000000001, 2'b10, 0, 0, "R3");
    send(64'h8000000000000001, 2'b11, 0, 0, "R3");
    send(64'h0008000000000000, 2'b00, 0, 0, "R3");
    idle(3);
    // R4 inf / NaN
    send(64'h7FF0000000000000, 2'b00, 0, 0, "R4");
    send(64'hFFF8000000000001, 2'b10, 0, 0, "R4");
    // R5 exact left shifts
    send(64'h4330000000000000, 2'b00, 0, 0, "R5");
    send(64'h43D0000000000001, 2'b10, 0, 0, "R5");
    send(64'hC33FFFFFFFFFFFFF, 2'b00, 0, 0, "R5");
    // R6 overflow and wrap
    send(64'h43E0000000000000, 2'b00, 0, 0, "R6");
    send(64'hC3E0000000000000, 2'b00, 0, 0, "R6");
    send(64'hC3E0000000000001, 2'b00, 0, 0, "R6");
    send(64'h43F0000000000000, 2'b00, 0, 0, "R6");
    send(64'h4730000000000000, 2'b00, 0, 0, "R5");
    send(64'h43E1234567890ABC, 2'b01, 0, 0, "R6");
    idle(2);
    // R7 fractional and deep shifts
    send(64'h3FE0000000000001, 2'b01, 0, 0, "R7");
    send(64'h3C00000000000000, 2'b10, 0, 0, "R7");
    send(64'h3FF0000000000000, 2'b11, 0, 0, "R7");
    // R8 ties to even
    send(64'h4004000000000000, 2'b00, 0, 0, "R8");
    send(64'h400C000000000000, 2'b00, 0, 0, "R8");
    send(64'h3FE0000000000000, 2'b00, 0, 0, "R8");
    send(64'h3FF8000000000001, 2'b00, 0, 0, "R8");
    // R9 / R10 directed modes, both signs
    for (int m = 0; m < 4; m++) begin
      send(64'h3FF8000000000000, 2'(m), 0, 0, "R9");
      send(64'hBFF8000000000000, 2'(m), 0, 0, "R10");
    end
    // R11 force truncate
    send(64'h400C000000000000, 2'b00, 1, 0, "R11");
    send(64'hBFF8000000000000, 2'b11, 1, 0, "R11");
    send(64'h0000000000000001, 2'b10, 1, 0, "R11");
    idle(4);
    // Random sweep around the integer range, R13 flag encoding
    for (int i = 0; i < 600; i++) begin
      logic [63:0] a;
      logic [10:0] e;
      a = {$urandom(), $urandom()};
      e = 11'(1000 + ($urandom() % 150));
      if (i % 5 != 0) a[62:52] = e;
      send(a, 2'($urandom()), 1'($urandom() % 4 == 0), 1'($urandom()), "R13");
      if (i % 7 == 0) idle(1);
    end
    idle(6);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 pending act=%0d exp=0", q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule